// File: doc/BRIEF.md
# Double to Signed 64-bit Integer Truncating Converter

This unit turns an IEEE-754 double-precision value into a signed 64-bit integer. It always truncates toward zero and ignores any rounding mode set elsewhere. The operand is taken from the low 64 bits of a 128-bit source vector. The integer goes into the low 64 bits of a 128-bit destination vector, and the high 64 bits of the destination are always written with zero.

Some inputs cannot be represented as a signed 64-bit integer: values that are too large, infinities and NaNs. For these the unit returns fixed saturation values and raises status flags. An upstream stage presents an operand together with a valid strobe. The converted result and its flags appear on a register one clock later. The trap handler and the sticky status register are outside this block and consume the flags.

Top module: `fp64_trunc_s64`

## Requirements
- R1: The result is placed in destination bits [63:0], and destination bits [127:64] are always zero. Source bits [127:64] have no effect on any output. The operand is source bits [63:0]: sign at bit 63, biased exponent at bits [62:52], fraction at bits [51:0].
- R2: An in-range input that is already an integer yields its exact two's-complement value with every flag clear. This includes 2^52+1 and 0x43DFFFFFFFFFFFFF, which yields 0x7FFFFFFFFFFFFC00.
- R3: An in-range input with a nonzero fraction yields its value truncated toward zero (2.5 gives 2, -2.5 gives -2). Both frac_inexact and inexact_exc are set.
- R4: Signed zeros yield 0 with no flags. Nonzero denormals and normals of magnitude below 1 yield 0 with frac_inexact and inexact_exc set.
- R5: An input of exactly -2^63 yields 0x8000000000000000 with no flag set.
- R6: Any value of 2^63 or more, any value below -2^63, and both infinities yield 0x8000000000000000 with invalid_cvt set and the inexact flags clear.
- R7: A NaN (exponent all ones, fraction nonzero) yields 0x8000000000000000 with invalid_cvt set. invalid_snan is also set exactly when the fraction MSB (bit 51) is 0, which marks a signalling NaN.
- R8: frac_rounded is 0 for every input.
- R9: A result and its flags appear on the clock edge after the one that samples in_valid high, and out_valid is high for that cycle. When in_valid is low, out_valid is low and the result and flags hold their values. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| src_vec | input | 128 | Source vector; operand in bits [63:0] |
| out_valid | output | 1 | Result registered from the previous cycle's operand |
| dst_vec | output | 128 | Destination vector; integer in [63:0], zero in [127:64] |
| frac_rounded | output | 1 | Fraction-rounded status, always 0 |
| frac_inexact | output | 1 | Fraction-inexact status |
| inexact_exc | output | 1 | Inexact exception |
| invalid_cvt | output | 1 | Invalid-conversion exception |
| invalid_snan | output | 1 | Signalling-NaN invalid exception |

## Verification
The converter keeps no state across operands, so a wrong shift amount, a lost sticky bit or a misdecoded class shows up on dst_vec or a flag in the cycle right after the operand is sampled. The directed operands sit on every class boundary: magnitudes just below 1 and 2^63, exactly -2^63 and 2^63, one ulp past -2^63, the two NaN kinds and both infinities. This way each misdecoded boundary gives a wrong value or flag on its own vector. A hold phase with in_valid low shows whether a stray capture would overwrite the registered result.

// File: rtl/fp64_trunc_s64.sv
module fp64_trunc_s64 (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [127:0] src_vec,
  output logic         out_valid,
  output logic [127:0] dst_vec,
  output logic         frac_rounded,
  output logic         frac_inexact,
  output logic         inexact_exc,
  output logic         invalid_cvt,
  output logic         invalid_snan
);

  localparam logic [63:0] INT_MIN = 64'h8000_0000_0000_0000;
  localparam logic [10:0] BIAS    = 11'd1023;
  localparam logic [10:0] EXP_OVF = 11'd1086;

  logic        sgn;
  logic [10:0] bexp;
  logic [51:0] frac;
  logic [5:0]  shamt;
  logic [115:0] wide;
  logic [63:0] mag;
  logic        sticky;

  assign sgn    = src_vec[63];
  assign bexp   = src_vec[62:52];
  assign frac   = src_vec[51:0];
  assign shamt  = 6'(bexp - BIAS);
  assign wide   = {63'b0, 1'b1, frac} << shamt;
  assign mag    = wide[115:52];
  assign sticky = |wide[51:0];

  logic [63:0] res;
  logic        fi_n, inv_n, sn_n;

  always_comb begin
    res   = '0;
    fi_n  = 1'b0;
    inv_n = 1'b0;
    sn_n  = 1'b0;
    if (&bexp && |frac) begin
      res   = INT_MIN;
      inv_n = 1'b1;
      sn_n  = ~frac[51];
    end else if (bexp >= EXP_OVF) begin
      res   = INT_MIN;
      inv_n = !(sgn && bexp == EXP_OVF && frac == '0);
    end else if (bexp < BIAS) begin
      fi_n  = |src_vec[62:0];
    end else begin
      res   = sgn ? -mag : mag;
      fi_n  = sticky;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      dst_vec      <= '0;
      frac_inexact <= 1'b0;
      inexact_exc  <= 1'b0;
      invalid_cvt  <= 1'b0;
      invalid_snan <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst_vec      <= {64'b0, res};
        frac_inexact <= fi_n;
        inexact_exc  <= fi_n;
        invalid_cvt  <= inv_n;
        invalid_snan <= sn_n;
      end
    end
  end

  assign frac_rounded = 1'b0;

  assert_snan_is_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_snan |-> invalid_cvt);

  assert_invalid_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_cvt |-> (dst_vec[63:0] == INT_MIN && !frac_inexact));

  assert_zero_in_zero_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bexp == 11'd0) |=> (dst_vec[63:0] == 64'd0 && !invalid_cvt));

  assert_positive_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sgn && bexp < EXP_OVF) |=> !dst_vec[63]);

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(dst_vec) && $stable(invalid_cvt)));

  assert_upper_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (dst_vec[127:64] == 64'd0 && !frac_rounded));

endmodule

// File: tb/fp64_trunc_s64_test.sv
module fp64_trunc_s64_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] src_vec = '0;
  logic         out_valid;
  logic [127:0] dst_vec;
  logic         frac_rounded, frac_inexact, inexact_exc, invalid_cvt, invalid_snan;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fp64_trunc_s64 uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .out_valid(out_valid), .dst_vec(dst_vec), .frac_rounded(frac_rounded),
    .frac_inexact(frac_inexact), .inexact_exc(inexact_exc),
    .invalid_cvt(invalid_cvt), .invalid_snan(invalid_snan)
  );

  typedef struct {
    logic [63:0] res;
    logic        fi;
    logic        inv;
    logic        sn;
    string       tag;
  } exp_t;

  exp_t sb[$];

  task automatic send(input logic [63:0] upper, input logic [63:0] op,
                      input logic [63:0] res, input logic fi, input logic inv,
                      input logic sn, input string tag);
    exp_t e;
    e.res = res; e.fi = fi; e.inv = inv; e.sn = sn; e.tag = tag;
    sb.push_back(e);
    in_valid = 1'b1;
    src_vec  = {upper, op};
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        exp_t e;
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R9: unexpected out_valid, actual dst %h expected none", dst_vec);
        end else begin
          e = sb.pop_front();
          if (dst_vec !== {64'b0, e.res} || frac_rounded !== 1'b0 ||
              frac_inexact !== e.fi || inexact_exc !== e.fi ||
              invalid_cvt !== e.inv || invalid_snan !== e.sn) begin
            errors++;
            $display("FAIL %s: actual dst=%h fr=%b fi=%b xx=%b inv=%b sn=%b expected dst=%h fr=0 fi=%b xx=%b inv=%b sn=%b",
                     e.tag, dst_vec, frac_rounded, frac_inexact, inexact_exc, invalid_cvt,
                     invalid_snan, {64'b0, e.res}, e.fi, e.fi, e.inv, e.sn);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic [127:0] held;
    repeat (3) @(negedge clk);
    checks++;
    if (dst_vec !== '0 || out_valid !== 1'b0 || invalid_cvt !== 1'b0 || frac_inexact !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: actual dst=%h ov=%b expected all zero", dst_vec, out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    send(64'h0, 64'h3FF0000000000000, 64'h0000000000000001, 0, 0, 0, "R2 one");
    send(64'h0, 64'hBFF0000000000000, 64'hFFFFFFFFFFFFFFFF, 0, 0, 0, "R2 minus one");
    send(64'h0, 64'h4330000000000001, 64'h0010000000000001, 0, 0, 0, "R2 2^52+1");
    send(64'h0, 64'h43D0000000000000, 64'h4000000000000000, 0, 0, 0, "R2 2^62");
    send(64'h0, 64'h43DFFFFFFFFFFFFF, 64'h7FFFFFFFFFFFFC00, 0, 0, 0, "R2 largest below 2^63");
    send(64'h0, 64'h4004000000000000, 64'h0000000000000002, 1, 0, 0, "R3 2.5");
    send(64'h0, 64'hC004000000000000, 64'hFFFFFFFFFFFFFFFE, 1, 0, 0, "R3 -2.5");
    send(64'h0, 64'h4320000000000001, 64'h0008000000000000, 1, 0, 0, "R3 2^51+0.5");
    send(64'h0, 64'h0000000000000000, 64'h0, 0, 0, 0, "R4 +0");
    send(64'h0, 64'h8000000000000000, 64'h0, 0, 0, 0, "R4 -0");
    send(64'h0, 64'h0000000000000001, 64'h0, 1, 0, 0, "R4 denormal");
    send(64'h0, 64'hBFE0000000000000, 64'h0, 1, 0, 0, "R4 -0.5");
    send(64'h0, 64'hC3E0000000000000, 64'h8000000000000000, 0, 0, 0, "R5 -2^63");
    send(64'h0, 64'h43E0000000000000, 64'h8000000000000000, 0, 1, 0, "R6 2^63");
    send(64'h0, 64'hC3E0000000000001, 64'h8000000000000000, 0, 1, 0, "R6 below -2^63");
    send(64'h0, 64'h7E37E43C8800759C, 64'h8000000000000000, 0, 1, 0, "R6 huge");
    send(64'h0, 64'h7FF0000000000000, 64'h8000000000000000, 0, 1, 0, "R6 +inf");
    send(64'h0, 64'hFFF0000000000000, 64'h8000000000000000, 0, 1, 0, "R6 -inf");
    send(64'h0, 64'h7FF8000000000000, 64'h8000000000000000, 0, 1, 0, "R7 qnan");
    send(64'h0, 64'h7FF0000000000001, 64'h8000000000000000, 0, 1, 1, "R7 snan");
    send(64'h0, 64'hFFF4000000000000, 64'h8000000000000000, 0, 1, 1, "R7 negative snan");
    send(64'hDEADBEEFCAFEF00D, 64'h4004000000000000, 64'h0000000000000002, 1, 0, 0, "R1 upper source ignored");
    send(64'hFFFFFFFFFFFFFFFF, 64'h0000000000000000, 64'h0, 0, 0, 0, "R1 R8 upper source ones");

    @(negedge clk);
    held = dst_vec;
    src_vec = {64'h0, 64'h7FF0000000000001};
    repeat (3) @(negedge clk);
    checks++;
    if (dst_vec !== held || out_valid !== 1'b0 || invalid_snan !== 1'b0) begin
      errors++;
      $display("FAIL R9 hold: actual dst=%h ov=%b sn=%b expected dst=%h ov=0 sn=0",
               dst_vec, out_valid, invalid_snan, held);
    end
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R9: actual %0d results missing expected 0", sb.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule